// File: doc/BRIEF.md
# Edge-Triggered Counter Capture with Input Qualification

This block records the value of an external free-running counter at the moment a chosen transition appears on an asynchronous capture pin. The pin is first brought into the system clock domain. A qualifier then decides whether a transition of the configured polarity has occurred, and the counter value is loaded into a holding register. A one-cycle event strobe reports the load to whatever logic consumes it.

Two control inputs set the behaviour. One picks which transition counts: high-to-low or low-to-high. The other switches on a noise filter. The filter runs at the system clock rate and accepts a new pin level only after a run of identical consecutive samples. With the filter off, the first synchronized sample that shows the selected transition fires the capture.

The counter is not part of this block. Its value arrives on an input port, and the captured value leaves on an output port.

Top module: `icap_unit`

## Requirements
- R1: While reset is asserted and directly after it is released, the captured value reads 0 and the event strobe is low. Reset does not by itself produce a capture, whatever the pin level.
- R2: With the filter off and polarity input `edge_rise_i`=0, a high-to-low pin change applied after clock edge 0 loads the capture register at edge 3. The value loaded is the `count_i` value present just before edge 3.
- R3: With the filter off and `edge_rise_i`=1, a low-to-high pin change produces a capture with the same timing as R2.
- R4: A pin transition of the polarity not selected never loads the capture register and never raises the strobe. Whenever a capture happens, the synchronized pin level in the preceding cycle equals the selected target level (1 for rising, 0 for falling).
- R5: With the filter on (`filt_en_i`=1), a clean pin change applied after edge 0 loads the capture register at edge 6. This takes four consecutive synchronized samples at the new level. The value loaded is the `count_i` value present just before edge 6.
- R6: With the filter on, a pin pulse that lasts 1 or 3 clock cycles causes no capture. A pulse that lasts 4 cycles is captured at edge 6.
- R7: The event strobe `cap_evt_o` is high for exactly one clock cycle per capture.
- R8: Changing `edge_rise_i` while the pin is steady causes no capture.
- R9: The captured value does not change except on a cycle where the event strobe is raised. A later capture overwrites it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; also the filter sampling clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | CNT_W (16) | Free-running counter value to snapshot |
| edge_rise_i | input | 1 | Polarity select: 1 = low-to-high, 0 = high-to-low |
| filt_en_i | input | 1 | 1 = require four matching samples before accepting a transition |
| cap_val_o | output | CNT_W (16) | Most recently captured counter value |
| cap_evt_o | output | 1 | One-cycle strobe marking a capture register load |

## Verification
The hardest case is the boundary of the filter window. A pulse held for three cycles must be rejected, while one held for four cycles must be accepted. Only exact control of the pin, measured in whole clock cycles, separates the two. The bench therefore drives the pin a fixed fraction of a period after each rising edge and holds it for a counted number of cycles. It also advances the counter input by one on every cycle, so that a capture that fires one cycle early or late shows up as a wrong value rather than just a wrong strobe time.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic {
        EDGE_FALLING = 1'b0,
        EDGE_RISING  = 1'b1
    } edge_pol_e;

    // Level the pin settles at after a transition of the given polarity
    function automatic logic target_level(edge_pol_e pol);
        return (pol == EDGE_RISING);
    endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/icap_qualifier.sv
module icap_qualifier import icap_pkg::*; #(
    parameter int FILT_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    input  logic edge_rise_i,
    input  logic filt_en_i,
    output logic hit_o
);
    localparam int HIST_W = FILT_LEN - 1;

    typedef struct packed {
        logic              prev;
        logic              filt;
        logic [HIST_W-1:0] hist;
    } state_t;

    state_t st_d, st_q;

    logic [FILT_LEN-1:0] window;
    logic                all_hi;
    logic                all_lo;
    logic                target;
    logic                raw_hit;
    logic                filt_hit;

    always_comb begin
        window   = {st_q.hist, lvl_i};
        all_hi   = &window;
        all_lo   = ~|window;
        target   = target_level(edge_pol_e'(edge_rise_i));

        st_d      = st_q;
        st_d.prev = lvl_i;
        st_d.hist = window[HIST_W-1:0];
        if (all_hi) begin
            st_d.filt = 1'b1;
        end else if (all_lo) begin
            st_d.filt = 1'b0;
        end

        raw_hit  = (lvl_i != st_q.prev) && (lvl_i == target);
        filt_hit = (st_d.filt != st_q.filt) && (st_d.filt == target);
        hit_o    = filt_en_i ? filt_hit : raw_hit;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{prev: lvl_i, filt: lvl_i, hist: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit import icap_pkg::*; #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cap_pin_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             edge_rise_i,
    input  logic             filt_en_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             cap_evt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic             evt;
    } state_t;

    state_t st_d, st_q;
    logic   sync_lvl;
    logic   hit;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .async_i(cap_pin_i),
        .sync_o (sync_lvl)
    );

    icap_qualifier #(.FILT_LEN(FILT_LEN)) u_qual (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lvl_i      (sync_lvl),
        .edge_rise_i(edge_rise_i),
        .filt_en_i  (filt_en_i),
        .hit_o      (hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.evt = hit;
        if (hit) begin
            st_d.cap = count_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_val_o = st_q.cap;
    assign cap_evt_o = st_q.evt;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
    parameter int CNT_W    = 16,
    parameter int FILT_LEN = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CNT_W-1:0] count_i,
    input logic             edge_rise_i,
    input logic             filt_en_i,
    input logic             sync_lvl_i,
    input logic [CNT_W-1:0] cap_val_o,
    input logic             cap_evt_o
);
    p_capture_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_evt_o |-> cap_val_o == $past(count_i));

    p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_evt_o |=> (!cap_evt_o || !$stable(edge_rise_i)));

    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_evt_o |-> $stable(cap_val_o));

    p_target_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_evt_o |-> $past(sync_lvl_i) == $past(edge_rise_i));

    if (FILT_LEN >= 4) begin : g_filt
        p_filter_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cap_evt_o && $past(filt_en_i)) |->
                ($past(sync_lvl_i, 1) == $past(sync_lvl_i, 2)) &&
                ($past(sync_lvl_i, 2) == $past(sync_lvl_i, 3)) &&
                ($past(sync_lvl_i, 3) == $past(sync_lvl_i, 4)));
    end
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W), .FILT_LEN(FILT_LEN)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_i    (count_i),
    .edge_rise_i(edge_rise_i),
    .filt_en_i  (filt_en_i),
    .sync_lvl_i (sync_lvl),
    .cap_val_o  (cap_val_o),
    .cap_evt_o  (cap_evt_o)
);

// File: tb/icap_unit_tb.sv
module icap_unit_tb;
    localparam int CLK_P = 10;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pin = 1'b1;
    logic [CNT_W-1:0] cnt = 16'h1000;
    logic             rise = 1'b0;
    logic             filt = 1'b0;
    logic [CNT_W-1:0] cap_val;
    logic             cap_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    icap_unit u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cap_pin_i  (pin),
        .count_i    (cnt),
        .edge_rise_i(rise),
        .filt_en_i  (filt),
        .cap_val_o  (cap_val),
        .cap_evt_o  (cap_evt)
    );

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
        cnt = cnt + 1'b1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick();
            chk(tag, cap_evt, 0);
        end
    endtask

    task automatic settle(input logic lvl);
        pin = lvl;
        for (int i = 0; i < 10; i++) tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pin = 1'b1; rise = 1'b0; filt = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        chk("R1 cap in reset", cap_val, 0);
        chk("R1 evt in reset", cap_evt, 0);
        rst_n = 1'b1;
        quiet(4, "R1 no capture after release");
        chk("R1 cap after release", cap_val, 0);
    endtask

    task automatic t_raw_fall();
        logic [CNT_W-1:0] v0;
        rise = 1'b0; filt = 1'b0;
        settle(1'b1);
        v0 = cnt; pin = 1'b0;
        quiet(2, "R2 not early");
        tick();
        chk("R2 evt at edge 3", cap_evt, 1);
        chk("R2 value", cap_val, v0 + 16'd2);
        tick();
        chk("R7 strobe one cycle", cap_evt, 0);
    endtask

    task automatic t_raw_rise();
        logic [CNT_W-1:0] v0;
        rise = 1'b1; filt = 1'b0;
        settle(1'b0);
        v0 = cnt; pin = 1'b1;
        quiet(2, "R3 not early");
        tick();
        chk("R3 evt at edge 3", cap_evt, 1);
        chk("R3 value", cap_val, v0 + 16'd2);
        tick();
        chk("R7 strobe one cycle rise", cap_evt, 0);
    endtask

    task automatic t_wrong_pol();
        logic [CNT_W-1:0] keep;
        rise = 1'b1; filt = 1'b0;
        settle(1'b1);
        keep = cap_val;
        pin = 1'b0;
        quiet(8, "R4 falling ignored when rising selected");
        chk("R4 value kept", cap_val, keep);
        rise = 1'b0;
        settle(1'b0);
        keep = cap_val;
        pin = 1'b1;
        quiet(8, "R4 rising ignored when falling selected");
        chk("R4 value kept 2", cap_val, keep);
    endtask

    task automatic t_sel_toggle();
        logic [CNT_W-1:0] keep;
        filt = 1'b0;
        settle(1'b1);
        keep = cap_val;
        rise = 1'b1;
        quiet(5, "R8 select change high pin");
        rise = 1'b0;
        quiet(5, "R8 select change back");
        chk("R9 value held", cap_val, keep);
    endtask

    task automatic t_filt_edge();
        logic [CNT_W-1:0] v0;
        rise = 1'b0; filt = 1'b1;
        settle(1'b1);
        v0 = cnt; pin = 1'b0;
        quiet(5, "R5 not before edge 6");
        tick();
        chk("R5 evt at edge 6", cap_evt, 1);
        chk("R5 value", cap_val, v0 + 16'd5);
        tick();
        chk("R7 strobe one cycle filt", cap_evt, 0);
    endtask

    task automatic t_glitch();
        logic [CNT_W-1:0] keep;
        logic [CNT_W-1:0] v0;
        rise = 1'b1; filt = 1'b1;
        settle(1'b0);
        keep = cap_val;
        pin = 1'b1; tick(); pin = 1'b0;
        quiet(10, "R6 one-cycle pulse rejected");
        pin = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        pin = 1'b0;
        quiet(10, "R6 three-cycle pulse rejected");
        chk("R6 value kept", cap_val, keep);
        v0 = cnt; pin = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R6 four-cycle pulse not early", cap_evt, 0);
        end
        pin = 1'b0;
        tick();
        chk("R6 four-cycle pulse not early", cap_evt, 0);
        tick();
        chk("R6 four-cycle pulse captured", cap_evt, 1);
        chk("R9 overwritten by new capture", cap_val, v0 + 16'd5);
    endtask

    initial begin
        t_reset();
        t_raw_fall();
        t_raw_rise();
        t_wrong_pol();
        t_sel_toggle();
        t_filt_edge();
        t_glitch();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule